// File: doc/BRIEF.md
# Soft-Value Loader and Decode Control Slave

This block is the bus-facing front end of an iterative soft-decision channel decoder. A host on a classic Wishbone bus loads 256 signed 6-bit soft values, five to a 32-bit write, into a register-based soft-value store. The decoder datapath reads that store through a combinational read port. The host then writes a control word that carries an iteration limit and an early-stop enable, and that write starts a decode.

The block drives a one-cycle start pulse to the decoder and holds a busy state until the decoder reports completion. At completion it latches the decoded word, the syndrome weight and the iteration count, and it raises a level interrupt. The host clears the interrupt by writing one to the done bit. Status, result and a fixed version word are readable. Everything runs on the bus clock.

Top module: `sdl_top`

## Requirements
- R1: Bus word address k (0 to 51) stores its bits [6j+5:6j], for j = 0 to 4, as soft value 5k+j. Bits [31:30] are ignored. After reset every stored value reads as zero on the decoder read port.
- R2: In word 51 only lane 0 (value 255) is stored. Lanes 1 to 4 of that word change no stored value, including value 0.
- R3: `wb_ack_o` is high for exactly one cycle, in the cycle after a cycle in which `wb_cyc_i` and `wb_stb_i` are both high. Reads of unmapped addresses and of the soft-value words return zero and are still acknowledged.
- R4: A write to address 0x40 starts a decode when the block is idle. Bits [5:0] are the iteration limit and bit 8 is the early-stop enable. `dec_start` pulses for one cycle, in the cycle after the write is accepted, with `dec_limit` and `dec_early_stop` already showing the written values. Address 0x40 reads back those two fields.
- R5: Status (address 0x41) bit 0 is busy. It is set by a start and stays set until the cycle after `dec_done`, whatever syndrome weight the decoder reports.
- R6: On `dec_done` the block latches `dec_bits` into address 0x42. It latches the syndrome weight into bits [15:0] of address 0x43 and the iteration count into bits [23:16] of the same word.
- R7: Address 0x44 returns the VERSION parameter. Writes to it have no effect.
- R8: Status bit 1 (done) and `irq_o` are set in the cycle after `dec_done`. Writing a 1 to status bit 1 clears both. Writing a 0 there leaves them unchanged.
- R9: While busy, soft-value writes and control writes are ignored. No stored value changes, and there is no new start pulse, limit or early-stop change.
- R10: A new start clears done, `irq_o` and both result registers, so no result of an earlier decode is visible during the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 8 | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_ack_o | output | 1 | Acknowledge |
| wb_dat_o | output | 32 | Read data |
| irq_o | output | 1 | Decode-complete interrupt |
| llr_raddr | input | 8 | Decoder read index into the soft-value store |
| llr_rdata | output | 6 | Soft value at llr_raddr |
| dec_start | output | 1 | One-cycle decode start |
| dec_limit | output | 6 | Iteration limit |
| dec_early_stop | output | 1 | Early-stop enable |
| dec_done | input | 1 | Decoder finished (single-cycle) |
| dec_bits | input | 32 | Decoded bits |
| dec_synd_wt | input | 9 | Final syndrome weight |
| dec_iters | input | 6 | Iterations used |

## Verification
A wrong lane index or word-to-value mapping shows on the decoder read port as soon as the loaded word is swept, and a wrapped index from the last word's unused lanes corrupts value 0. A wrong busy or done state shows in the very next cycle as a missing or extra start pulse, or as a stuck or early interrupt. It also shows on the next status read. The bench compares acknowledge, start, limit, early-stop and interrupt against a behavioural model on every clock, so a state error is caught within one cycle of when it arises. Stale results surface on the first result read after a new start.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    localparam int BUS_DW = 32;
    localparam int BUS_AW = 8;

    // register word addresses
    localparam logic [BUS_AW-1:0] A_CTRL = 8'h40;
    localparam logic [BUS_AW-1:0] A_STAT = 8'h41;
    localparam logic [BUS_AW-1:0] A_BITS = 8'h42;
    localparam logic [BUS_AW-1:0] A_META = 8'h43;
    localparam logic [BUS_AW-1:0] A_VER  = 8'h44;

    localparam int CTRL_EARLY_BIT = 8;
    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_DONE_BIT  = 1;
    localparam int META_ITER_LSB  = 16;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [BUS_AW-1:0] adr;
        logic [BUS_DW-1:0] dat;
    } bus_req_t;

    typedef enum logic [0:0] {
        RUN_IDLE = 1'b0,
        RUN_BUSY = 1'b1
    } run_state_t;

    function automatic int unsigned words_for(input int unsigned n, input int unsigned per);
        return (n + per - 1) / per;
    endfunction

endpackage

// File: rtl/sdl_bus_slave.sv
module sdl_bus_slave
    import sdl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [BUS_AW-1:0] adr,
    input  logic [BUS_DW-1:0] wdat,
    output logic              ack,
    output bus_req_t          req
);

    logic ack_q;
    logic take;

    assign take = cyc && stb && !ack_q;

    always_comb begin
        req.wr  = take && we;
        req.rd  = take && !we;
        req.adr = adr;
        req.dat = wdat;
    end

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= take;
    end

    assign ack = ack_q;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);                                        // R3
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(cyc && stb));                           // R3

endmodule

// File: rtl/sdl_soft_mem.sv
module sdl_soft_mem
    import sdl_pkg::*;
#(
    parameter int N_VAL    = 256,
    parameter int VAL_W    = 6,
    parameter int PER_WORD = 5,
    localparam int N_WORDS = int'(words_for(N_VAL, PER_WORD)),
    localparam int MEM_AW  = $clog2(N_VAL),
    localparam int WIDX_W  = $clog2(N_WORDS * PER_WORD) + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      busy,
    input  logic                      wr_en,
    input  logic [BUS_AW-1:0]         wr_adr,
    input  logic [PER_WORD*VAL_W-1:0] wr_dat,
    input  logic [MEM_AW-1:0]         raddr,
    output logic [VAL_W-1:0]          rdata
);

    logic [VAL_W-1:0]  mem [N_VAL];
    logic              word_hit;
    logic [PER_WORD-1:0] lane_we;
    logic [WIDX_W-1:0] lane_idx [PER_WORD];

    assign word_hit = wr_en && !busy && (wr_adr < BUS_AW'(N_WORDS));

    for (genvar j = 0; j < PER_WORD; j++) begin : g_lane
        assign lane_idx[j] = WIDX_W'(wr_adr) * WIDX_W'(PER_WORD) + WIDX_W'(j);
        assign lane_we[j]  = word_hit && (lane_idx[j] < WIDX_W'(N_VAL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_VAL; i++) mem[i] <= '0;
        end else begin
            for (int j = 0; j < PER_WORD; j++) begin
                if (lane_we[j]) mem[lane_idx[j][MEM_AW-1:0]] <= wr_dat[j*VAL_W +: VAL_W];
            end
        end
    end

    assign rdata = mem[raddr];

    AST_FROZEN_FIRST: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mem[0]));                            // R9
    AST_FROZEN_LAST: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mem[N_VAL-1]));                      // R9
    AST_TAIL_SINGLE_LANE: assert property (@(posedge clk) disable iff (rst)
        (word_hit && wr_adr == BUS_AW'(N_WORDS-1)) |-> $countones(lane_we) == N_VAL - (N_WORDS-1)*PER_WORD); // R2

endmodule

// File: rtl/sdl_decode_ctrl.sv
module sdl_decode_ctrl
    import sdl_pkg::*;
#(
    parameter int          ITER_W  = 6,
    parameter int          SYN_W   = 9,
    parameter logic [31:0] VERSION = 32'h0001_0300
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              dec_done,
    input  logic [BUS_DW-1:0] dec_bits,
    input  logic [SYN_W-1:0]  dec_synd_wt,
    input  logic [ITER_W-1:0] dec_iters,
    output logic              busy,
    output logic              dec_start,
    output logic [ITER_W-1:0] dec_limit,
    output logic              dec_early_stop,
    output logic              irq,
    output logic [BUS_DW-1:0] rdata
);

    run_state_t        st;
    logic              done_q;
    logic [BUS_DW-1:0] res_bits;
    logic [SYN_W-1:0]  res_synd;
    logic [ITER_W-1:0] res_iters;
    logic              launch, finish, ack_done;
    logic [BUS_DW-1:0] rd_next;
    logic              unused_dat;

    assign unused_dat = ^req.dat;

    assign busy     = (st == RUN_BUSY);
    assign launch   = req.wr && (req.adr == A_CTRL) && (st == RUN_IDLE);
    assign finish   = (st == RUN_BUSY) && dec_done;
    assign ack_done = req.wr && (req.adr == A_STAT) && req.dat[STAT_DONE_BIT];

    always_comb begin
        rd_next = '0;
        if (req.rd) begin
            case (req.adr)
                A_CTRL: rd_next = BUS_DW'(dec_limit) | (BUS_DW'(dec_early_stop) << CTRL_EARLY_BIT);
                A_STAT: rd_next = (BUS_DW'(busy) << STAT_BUSY_BIT) | (BUS_DW'(done_q) << STAT_DONE_BIT);
                A_BITS: rd_next = res_bits;
                A_META: rd_next = (BUS_DW'(res_iters) << META_ITER_LSB) | BUS_DW'(res_synd);
                A_VER:  rd_next = VERSION;
                default: rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st             <= RUN_IDLE;
            dec_start      <= 1'b0;
            dec_limit      <= '0;
            dec_early_stop <= 1'b0;
            done_q         <= 1'b0;
            res_bits       <= '0;
            res_synd       <= '0;
            res_iters      <= '0;
            rdata          <= '0;
        end else begin
            dec_start <= launch;
            rdata     <= rd_next;
            if (launch) begin
                st             <= RUN_BUSY;
                dec_limit      <= req.dat[ITER_W-1:0];
                dec_early_stop <= req.dat[CTRL_EARLY_BIT];
                done_q         <= 1'b0;
                res_bits       <= '0;
                res_synd       <= '0;
                res_iters      <= '0;
            end else if (finish) begin
                st        <= RUN_IDLE;
                done_q    <= 1'b1;
                res_bits  <= dec_bits;
                res_synd  <= dec_synd_wt;
                res_iters <= dec_iters;
            end else if (ack_done) begin
                done_q <= 1'b0;
            end
        end
    end

    assign irq = done_q;

    AST_START_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        dec_start |=> !dec_start);                            // R4
    AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
        dec_start |-> busy);                                  // R4
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !dec_done) |=> busy);                        // R5
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (busy && dec_done) |=> (!busy && irq));               // R5
    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(dec_done));                      // R8
    AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        dec_start |-> (!irq && res_bits == '0 && res_iters == '0)); // R10
    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !dec_start) |-> $stable(dec_limit));         // R9

endmodule

// File: rtl/sdl_top.sv
module sdl_top
    import sdl_pkg::*;
#(
    parameter int          N_VAL    = 256,
    parameter int          VAL_W    = 6,
    parameter int          PER_WORD = 5,
    parameter int          ITER_W   = 6,
    parameter int          SYN_W    = 9,
    parameter logic [31:0] VERSION  = 32'h0001_0300,
    localparam int         MEM_AW   = $clog2(N_VAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [BUS_AW-1:0] wb_adr_i,
    input  logic [BUS_DW-1:0] wb_dat_i,
    output logic              wb_ack_o,
    output logic [BUS_DW-1:0] wb_dat_o,
    output logic              irq_o,
    input  logic [MEM_AW-1:0] llr_raddr,
    output logic [VAL_W-1:0]  llr_rdata,
    output logic              dec_start,
    output logic [ITER_W-1:0] dec_limit,
    output logic              dec_early_stop,
    input  logic              dec_done,
    input  logic [BUS_DW-1:0] dec_bits,
    input  logic [SYN_W-1:0]  dec_synd_wt,
    input  logic [ITER_W-1:0] dec_iters
);

    bus_req_t req;
    logic     busy;

    sdl_bus_slave u_bus (
        .clk  (clk),
        .rst  (rst),
        .cyc  (wb_cyc_i),
        .stb  (wb_stb_i),
        .we   (wb_we_i),
        .adr  (wb_adr_i),
        .wdat (wb_dat_i),
        .ack  (wb_ack_o),
        .req  (req)
    );

    sdl_soft_mem #(
        .N_VAL    (N_VAL),
        .VAL_W    (VAL_W),
        .PER_WORD (PER_WORD)
    ) u_mem (
        .clk    (clk),
        .rst    (rst),
        .busy   (busy),
        .wr_en  (req.wr),
        .wr_adr (req.adr),
        .wr_dat (req.dat[PER_WORD*VAL_W-1:0]),
        .raddr  (llr_raddr),
        .rdata  (llr_rdata)
    );

    sdl_decode_ctrl #(
        .ITER_W  (ITER_W),
        .SYN_W   (SYN_W),
        .VERSION (VERSION)
    ) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req            (req),
        .dec_done       (dec_done),
        .dec_bits       (dec_bits),
        .dec_synd_wt    (dec_synd_wt),
        .dec_iters      (dec_iters),
        .busy           (busy),
        .dec_start      (dec_start),
        .dec_limit      (dec_limit),
        .dec_early_stop (dec_early_stop),
        .irq            (irq_o),
        .rdata          (wb_dat_o)
    );

endmodule

// File: tb/sim_sdl_top.sv
module sim_sdl_top;

    localparam logic [31:0] VER = 32'h0001_0300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 0, stb = 0, we = 0;
    logic [7:0]  adr = '0;
    logic [31:0] wdat = '0;
    logic        ack;
    logic [31:0] rdat;
    logic        irq;
    logic [7:0]  raddr = '0;
    logic [5:0]  rval;
    logic        start;
    logic [5:0]  limit;
    logic        early;
    logic        done = 0;
    logic [31:0] dbits = '0;
    logic [8:0]  dsyn = '0;
    logic [5:0]  diter = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sdl_top u0 (
        .clk(clk), .rst(rst),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(wdat),
        .wb_ack_o(ack), .wb_dat_o(rdat), .irq_o(irq),
        .llr_raddr(raddr), .llr_rdata(rval),
        .dec_start(start), .dec_limit(limit), .dec_early_stop(early),
        .dec_done(done), .dec_bits(dbits), .dec_synd_wt(dsyn), .dec_iters(diter)
    );

    // behavioural reference model
    logic       m_ack = 0, m_start = 0, m_busy = 0, m_done = 0, m_early = 0;
    logic [5:0] m_limit = '0;
    logic [5:0] mem_m [256];
    bit         req;

    initial for (int i = 0; i < 256; i++) mem_m[i] = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_ack <= 0; m_start <= 0; m_busy <= 0; m_done <= 0; m_early <= 0; m_limit <= '0;
        end else begin
            req = cyc && stb && !m_ack;
            m_ack   <= req;
            m_start <= req && we && adr == 8'h40 && !m_busy;
            if (req && we && adr == 8'h40 && !m_busy) begin
                m_busy <= 1; m_done <= 0; m_limit <= wdat[5:0]; m_early <= wdat[8];
            end else if (m_busy && done) begin
                m_busy <= 0; m_done <= 1;
            end else if (req && we && adr == 8'h41 && wdat[1]) begin
                m_done <= 0;
            end
            if (req && we && adr < 52 && !m_busy)
                for (int j = 0; j < 5; j++)
                    if (adr * 5 + j < 256) mem_m[adr * 5 + j] = wdat[j*6 +: 6];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R3 ack timing", 32'(ack), 32'(m_ack));
            chk("R4 start pulse", 32'(start), 32'(m_start));
            chk("R4 limit out", 32'(limit), 32'(m_limit));
            chk("R4 early out", 32'(early), 32'(m_early));
            chk("R8 irq level", 32'(irq), 32'(m_done));
        end
    end

    task automatic bus(input bit w, input logic [7:0] a, input logic [31:0] d, output logic [31:0] r);
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; wdat = d;
        @(negedge clk);
        r = rdat;
        cyc = 0; stb = 0; we = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r;
        bus(1, a, d, r);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] r;
        bus(0, a, 32'h0, r);
        chk(tag, r, exp);
    endtask

    function automatic logic [5:0] pat(input int p, input int i);
        if (i > 255) return 6'h2A;
        return (p == 0) ? 6'((i * 7 + 3) & 63) : 6'((i * 13 + 40) & 63);
    endfunction

    task automatic load(input int p);
        for (int k = 0; k < 52; k++) begin
            logic [31:0] w;
            w = 32'hC000_0000;
            for (int j = 0; j < 5; j++) w[j*6 +: 6] = pat(p, k * 5 + j);
            wr(8'(k), w);
        end
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            raddr = 8'(i);
            #1;
            chk(tag, 32'(rval), 32'(mem_m[i]));
        end
    endtask

    task automatic decoder_finish(input logic [31:0] b, input logic [8:0] s, input logic [5:0] it);
        repeat (3) @(negedge clk);
        done = 1; dbits = b; dsyn = s; diter = it;
        @(negedge clk);
        done = 0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;

        // reset state
        chk("R3 ack after reset", 32'(ack), 0);
        chk("R8 irq after reset", 32'(irq), 0);
        rd_chk("R5 status after reset", 8'h41, 0);
        rd_chk("R6 bits after reset", 8'h42, 0);
        rd_chk("R6 meta after reset", 8'h43, 0);
        rd_chk("R7 version", 8'h44, VER);
        rd_chk("R3 unmapped read", 8'h7F, 0);
        rd_chk("R3 soft-value word read", 8'h03, 0);
        sweep("R1 reset contents");

        // packing, ignored top bits, tail lanes
        load(0);
        sweep("R1 R2 packed load");
        @(negedge clk) raddr = 8'd0; #1;
        chk("R2 value 0 untouched by tail lanes", 32'(rval), 32'(pat(0, 0)));
        @(negedge clk) raddr = 8'd255; #1;
        chk("R2 value 255 from word 51 lane 0", 32'(rval), 32'(pat(0, 255)));

        // version is read-only
        wr(8'h44, 32'hFFFF_FFFF);
        rd_chk("R7 version after write", 8'h44, VER);

        // first decode: converges
        wr(8'h40, 32'h0000_011E);
        rd_chk("R5 busy while decoding", 8'h41, 32'h1);
        rd_chk("R4 control readback", 8'h40, 32'h0000_011E);
        wr(8'h00, 32'h0000_0000);
        wr(8'h40, 32'h0000_0005);
        rd_chk("R9 control write ignored while busy", 8'h40, 32'h0000_011E);
        decoder_finish(32'hDEAD_BEEF, 9'd0, 6'd7);
        rd_chk("R5 R8 status after done", 8'h41, 32'h2);
        rd_chk("R6 decoded bits", 8'h42, 32'hDEAD_BEEF);
        rd_chk("R6 syndrome and iterations", 8'h43, 32'h0007_0000);
        sweep("R9 store unchanged by busy write");

        // interrupt clearing
        wr(8'h41, 32'h0000_0000);
        chk("R8 irq kept on zero write", 32'(irq), 1);
        wr(8'h41, 32'h0000_0002);
        chk("R8 irq cleared", 32'(irq), 0);

        // second decode: limit reached, nonzero syndrome, no stale results
        wr(8'h40, 32'h0000_000C);
        rd_chk("R10 bits cleared at start", 8'h42, 0);
        rd_chk("R10 meta cleared at start", 8'h43, 0);
        rd_chk("R10 done cleared at start", 8'h41, 32'h1);
        decoder_finish(32'h1234_5678, 9'd5, 6'd12);
        rd_chk("R5 busy clears without zero syndrome", 8'h41, 32'h2);
        rd_chk("R6 meta nonzero syndrome", 8'h43, 32'h000C_0005);

        // third decode started with irq still pending
        wr(8'h40, 32'h0000_0103);
        chk("R10 irq dropped by new start", 32'(irq), 0);
        decoder_finish(32'h0F0F_0F0F, 9'd2, 6'd3);
        rd_chk("R6 third bits", 8'h42, 32'h0F0F_0F0F);

        // reload a second pattern while idle
        load(1);
        sweep("R1 second pattern");

        repeat (2) @(negedge clk);
        summary();
    end

endmodule